// File: doc/BRIEF.md
# Steerable Programmable Watchdog

This block is a countdown watchdog configured through one byte-wide control register. The low two bits pick a resolution and the next five bits a multiplier. Together they set a timeout measured in periods of an external 16 Hz tick strobe, so one tick is 1/16 s. Software keeps the system alive by writing or reading the register. Either access restarts the countdown and clears the expiry flag.

When the countdown runs out, the block raises a sticky expiry flag. The top bit of the register then steers the outcome. With the bit set, the register is cleared and a one-cycle reset request is issued, together with a one-cycle strobe that tells the neighbouring calendar logic to clear its century bit. With the bit clear, a single interrupt pulse is issued instead. Either way the countdown stops until the next access.

Top module: `wdt_steer`

## Requirements
- R1: The timeout is T = mult * 4^res ticks, where res = register bits [1:0] and mult = register bits [6:2]. Expiry happens on the T-th tick_i pulse after the countdown was loaded. The expiry outputs are high in the clock cycle that follows the one in which that tick was sampled.
- R2: A multiplier of zero disables the watchdog, including a register value of zero. No expiry occurs however many ticks arrive, and the stored value is unchanged.
- R3: A write (wr_en_i) stores wdata_i, which rdata_o shows from the next cycle. The write clears expired_o and restarts the countdown from the timeout of the new value.
- R4: A read strobe (rd_en_i) without a write restarts the countdown from the timeout of the stored value and clears expired_o.
- R5: On expiry expired_o goes to 1 and stays at 1 until the next access. An access and a synchronous clear do not happen together here.
- R6: If register bit 7 is 1 at expiry, the register becomes 0x00, rst_req_o and century_clr_o each pulse high for exactly one cycle, and irq_o stays low. Afterwards the countdown stays idle.
- R7: If register bit 7 is 0 at expiry, irq_o pulses high for exactly one cycle, rst_req_o and century_clr_o stay low, and the register keeps its value. No further expiry occurs until the next access.
- R8: An access in the same cycle as the tick that would end the countdown takes priority. No expiry occurs and the countdown restarts.
- R9: srst_i clears the register and the countdown and discards any access in the same cycle. It leaves expired_o unchanged.
- R10: While rst_ni is low, rdata_o is 0x00 and expired_o, rst_req_o, irq_o and century_clr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear of register and countdown |
| tick_i | input | 1 | One-cycle strobe at 16 Hz |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (restarts countdown) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Stored register value |
| expired_o | output | 1 | Sticky expiry flag |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| century_clr_o | output | 1 | One-cycle strobe to clear the calendar century bit |

## Verification
The hardest case to reach is a collision: an access in exactly the cycle whose tick would end the countdown. The bench loads a short timeout and delivers all but one of its ticks. It then raises the final tick and a read strobe on the same clock edge, and checks that no pulse appears and that a full fresh timeout follows. The longest timeout is also driven all the way to expiry, one tick at a time, so that the widest shift of the multiplier is exercised at its boundary tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned RES_W    = 2;
  localparam int unsigned RES_STEP = 2;  // each resolution step multiplies by 2^RES_STEP
  localparam int unsigned MULT_LSB = RES_W;
  localparam int unsigned MULT_W   = 5;
  localparam int unsigned STEER_B  = MULT_LSB + MULT_W;
  localparam int unsigned RES_N    = 1 << RES_W;
  localparam int unsigned CNT_W    = MULT_W + RES_STEP * (RES_N - 1);
endpackage

// File: rtl/wdt_span.sv
module wdt_span
  import wdt_pkg::*;
(
  input  logic [REG_W-1:0] cfg_i,
  output logic [CNT_W-1:0] span_o
);
  logic [CNT_W-1:0] cand [RES_N];
  logic [MULT_W-1:0] mult;

  assign mult = cfg_i[MULT_LSB +: MULT_W];

  for (genvar g = 0; g < RES_N; g++) begin : g_res
    assign cand[g] = CNT_W'(mult) << (RES_STEP * g);
  end

  assign span_o = cand[cfg_i[RES_W-1:0]];
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  // zero means idle; expiry on the tick that takes 1 to 0
  assign fire_o = tick_i && (cnt_q == CNT_W'(1)) && !load_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdt_fire.sv
module wdt_fire (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fire_i,
  input  logic steer_i,
  output logic rst_req_o,
  output logic irq_o,
  output logic century_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o     <= 1'b0;
      irq_o         <= 1'b0;
      century_clr_o <= 1'b0;
    end else begin
      rst_req_o     <= fire_i && steer_i && !clr_i;
      century_clr_o <= fire_i && steer_i && !clr_i;
      irq_o         <= fire_i && !steer_i && !clr_i;
    end
  end
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             expired_o,
  output logic             rst_req_o,
  output logic             irq_o,
  output logic             century_clr_o
);
  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] load_src;
  logic [CNT_W-1:0] span;
  logic             access;
  logic             fire;
  logic             flag_q;

  assign access   = (wr_en_i || rd_en_i) && !srst_i;
  assign load_src = wr_en_i ? wdata_i : cfg_q;

  wdt_span u_span (
    .cfg_i  (load_src),
    .span_o (span)
  );

  wdt_down_cnt u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (srst_i),
    .load_i     (access),
    .load_val_i (span),
    .tick_i     (tick_i),
    .fire_o     (fire)
  );

  wdt_fire u_fire (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (srst_i),
    .fire_i        (fire),
    .steer_i       (cfg_q[STEER_B]),
    .rst_req_o     (rst_req_o),
    .irq_o         (irq_o),
    .century_clr_o (century_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cfg_q <= '0;
    else if (srst_i)                   cfg_q <= '0;
    else if (wr_en_i)                  cfg_q <= wdata_i;
    else if (fire && cfg_q[STEER_B])   cfg_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (access)  flag_q <= 1'b0;
    else if (fire)    flag_q <= 1'b1;
  end

  assign rdata_o   = cfg_q;
  assign expired_o = flag_q;
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk
  import wdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             srst_i,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             expired_o,
  input logic             rst_req_o,
  input logic             irq_o,
  input logic             century_clr_o
);
  p_rst_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  p_rst_clears_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rdata_o == '0) && expired_o && !irq_o);

  p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_sets_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> expired_o && !rst_req_o && !century_clr_o);

  p_access_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || rd_en_i) && !srst_i) |=> !expired_o && !irq_o && !rst_req_o);

  p_zero_mult_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[MULT_LSB +: MULT_W] == '0 && !wr_en_i) |=> !(irq_o || rst_req_o));

  p_srst_keeps_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> $stable(expired_o) && (rdata_o == '0));
endmodule

bind wdt_steer wdt_steer_chk u_chk (.*);

// File: tb/sim_wdt_steer.sv
`timescale 1ns/1ps
module sim_wdt_steer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       expired_o, rst_req_o, irq_o, century_clr_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  wdt_steer u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pulses as {rst_req, century_clr, irq}
  function automatic logic [15:0] pulses();
    return {13'd0, rst_req_o, century_clr_o, irq_o};
  endfunction

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk_i) begin wr_en_i = 1'b1; wdata_i = v; end
    @(negedge clk_i) wr_en_i = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk_i) rd_en_i = 1'b1;
    @(negedge clk_i) rd_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 rdata", 16'(rdata_o), 16'h00);
    chk("R10 flag", 16'(expired_o), 16'h0);
    chk("R10 pulses", pulses(), 16'h0);
  endtask

  // irq path: value v, timeout n ticks
  task automatic t_irq(input string tag, input logic [7:0] v, input int n);
    wr(v);
    chk({tag, " R3 stored"}, 16'(rdata_o), 16'(v));
    chk({tag, " R3 flag clear"}, 16'(expired_o), 16'h0);
    tick_n(n - 1);
    chk({tag, " R1 early"}, pulses(), 16'h0);
    chk({tag, " R1 early flag"}, 16'(expired_o), 16'h0);
    tick_n(1);
    chk({tag, " R7 irq"}, pulses(), 16'h1);
    chk({tag, " R5 flag"}, 16'(expired_o), 16'h1);
    chk({tag, " R7 reg kept"}, 16'(rdata_o), 16'(v));
    @(negedge clk_i);
    chk({tag, " R7 single"}, pulses(), 16'h0);
    tick_n(n + 2);
    chk({tag, " R7 one-shot"}, pulses(), 16'h0);
    chk({tag, " R5 sticky"}, 16'(expired_o), 16'h1);
  endtask

  task automatic t_reset_path();
    wr(8'h85);
    tick_n(3);
    chk("R6 early", pulses(), 16'h0);
    tick_n(1);
    chk("R6 rst+century", pulses(), 16'h6);
    chk("R6 reg zero", 16'(rdata_o), 16'h00);
    chk("R6 flag", 16'(expired_o), 16'h1);
    @(negedge clk_i);
    chk("R6 single", pulses(), 16'h0);
    tick_n(20);
    chk("R6 idle", pulses(), 16'h0);
  endtask

  task automatic t_zero();
    wr(8'h00);
    tick_n(100);
    chk("R2 zero value", pulses(), 16'h0);
    wr(8'h80);
    tick_n(100);
    chk("R2 zero mult", pulses(), 16'h0);
    chk("R2 reg unchanged", 16'(rdata_o), 16'h80);
    chk("R2 flag", 16'(expired_o), 16'h0);
  endtask

  task automatic t_read_restart();
    // flag is set from a previous expiry here
    rd();
    chk("R4 read clears flag", 16'(expired_o), 16'h0);
    wr(8'h0C);   // 3 ticks
    tick_n(2);
    rd();
    tick_n(2);
    chk("R4 restarted", pulses(), 16'h0);
    tick_n(1);
    chk("R4 expiry after read", pulses(), 16'h1);
    chk("R4 reg after read", 16'(rdata_o), 16'h0C);
  endtask

  task automatic t_write_restart();
    wr(8'h0C);   // 3 ticks
    tick_n(2);
    wr(8'h05);   // 4 ticks
    tick_n(3);
    chk("R3 new value used", pulses(), 16'h0);
    tick_n(1);
    chk("R3 expiry new value", pulses(), 16'h1);
  endtask

  task automatic t_collide();
    wr(8'h0C);   // 3 ticks
    tick_n(2);
    @(negedge clk_i) begin tick_i = 1'b1; rd_en_i = 1'b1; end
    @(negedge clk_i) begin tick_i = 1'b0; rd_en_i = 1'b0; end
    chk("R8 no expiry", pulses(), 16'h0);
    chk("R8 flag clear", 16'(expired_o), 16'h0);
    tick_n(2);
    chk("R8 full restart", pulses(), 16'h0);
    tick_n(1);
    chk("R8 later expiry", pulses(), 16'h1);
  endtask

  task automatic t_srst();
    // flag is 1 from the previous expiry
    wr(8'h8C);
    tick_n(1);
    @(negedge clk_i) begin srst_i = 1'b1; wr_en_i = 1'b1; wdata_i = 8'h55; end
    @(negedge clk_i) begin srst_i = 1'b0; wr_en_i = 1'b0; end
    chk("R9 reg cleared", 16'(rdata_o), 16'h00);
    chk("R9 flag unchanged", 16'(expired_o), 16'h0);
    tick_n(10);
    chk("R9 idle", pulses(), 16'h0);
    // now with the flag set
    wr(8'h04);   // 1 tick
    tick_n(1);
    chk("R9 setup flag", 16'(expired_o), 16'h1);
    @(negedge clk_i) srst_i = 1'b1;
    @(negedge clk_i) srst_i = 1'b0;
    chk("R9 flag kept", 16'(expired_o), 16'h1);
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_irq("res0", 8'h0C, 3);
    t_irq("res1", 8'h05, 4);
    t_irq("res2", 8'h0A, 32);
    t_irq("res3", 8'h07, 64);
    t_irq("max",  8'h7F, 1984);
    t_read_restart();
    t_reset_path();
    t_zero();
    t_write_restart();
    t_collide();
    t_srst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule